// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

This block is a synchronous single-port memory with registered inputs and registered read outputs. Every command is taken on a rising clock edge. A read returns its word from a registered output stage, which is updated on the edge after the address. A write supplies its data on the edge after its address, which is the late-write protocol. The captured word waits in a one-entry write buffer. The buffer commits it to the array when the next write arrives.

Reads stay coherent with writes. A read whose address matches the buffered entry merges the buffered bytes that were enabled with the array bytes that were not. Byte enables select which 9-bit lanes a write touches. The output-enable input and the sleep input act combinationally on the bus drive. Sleep also blocks new commands and keeps the stored contents. The shared data bus appears as a separate input, a separate output and a drive-enable output.

Top module: `lw_sram`

## Requirements
- R1: After an active-low asynchronous reset, the block does not drive the bus (`dq_oe_o` = 0) and the write buffer holds no entry.
- R2: A read command (`en_i`=1, `we_i`=0) sampled on edge N places the addressed word on `dq_o` from edge N+1. `dq_oe_o` is high from edge N+1 while `oe_i` is 1.
- R3: A write command (`en_i`=1, `we_i`=1) sampled on edge N takes its data word from `dq_i` on edge N+1.
- R4: A read of the address held in the write buffer returns the buffered data. This includes a read issued on the cycle directly after the write.
- R5: `be_i` bit b enables byte lane `dq[9b+8:9b]`. A write changes only the enabled lanes. Its disabled lanes keep their earlier values, both in the buffer merge and after commit.
- R6: The buffered word is committed to the array when the next write's data is captured. Reads after any number of writes return the data in program order.
- R7: `oe_i` low forces `dq_oe_o` low within the same cycle. Raising `oe_i` again restores the drive without waiting for a clock edge.
- R8: During a write's data cycle (after edge N, up to edge N+1) the block never drives the bus. A read issued just before a write therefore loses its bus slot.
- R9: While `sleep_i` is high, `dq_oe_o` is low, commands are ignored and the array and buffer keep their contents. Commands are taken again on the first edge after `sleep_i` falls.
- R10: A cycle with `en_i` low is a no-op. It changes no data, and two edges later the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising-edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Command select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| be_i | input | NB | Byte-lane write enables |
| dq_i | input | NB*BW | Incoming write data (late-write cycle) |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous power-down request |
| dq_o | output | NB*BW | Registered read data |
| dq_oe_o | output | 1 | Bus drive enable for dq_o |

## Verification
A buffer commit and a coherent read can fall in the same cycle window. This happens when a write is followed at once by a read of the same address. It is provoked for every address and for all sixteen byte-enable patterns, with a second partial write committing the first. Every read is judged against a reference array that the bench updates in program order. Turnaround is also provoked: a read directly followed by a write must leave the bus undriven.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } cmd_e;
endpackage

// File: rtl/lw_sram_cmd_reg.sv
module lw_sram_cmd_reg
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NB     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  output cmd_e              kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NB-1:0]     be_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= CMD_NOP;
      addr_o <= '0;
      be_o   <= '0;
    end else begin
      addr_o <= addr_i;
      be_o   <= be_i;
      if (sleep_i || !en_i) kind_o <= CMD_NOP;
      else                  kind_o <= we_i ? CMD_WR : CMD_RD;
    end
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int NB     = 4,
  parameter int BW     = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [NB-1:0]     wbe_i,
  input  logic [NB*BW-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [NB*BW-1:0]  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int W     = NB * BW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (wbe_i[b]) mem_q[waddr_i][b*BW +: BW] <= wdata_i[b*BW +: BW];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int ADDR_W = 6,
  parameter int NB     = 4,
  parameter int BW     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  input  logic [NB*BW-1:0]  data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [NB*BW-1:0]  arr_rd_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [NB-1:0]     cm_be_o,
  output logic [NB*BW-1:0]  cm_data_o,
  output logic [NB*BW-1:0]  merged_o
);
  logic valid_q;
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      cm_addr_o <= '0;
      cm_be_o   <= '0;
      cm_data_o <= '0;
    end else if (cap_i) begin
      valid_q   <= 1'b1;
      cm_addr_o <= addr_i;
      cm_be_o   <= be_i;
      cm_data_o <= data_i;
    end
  end

  // old entry retires on the same edge the new one lands
  assign commit_o = cap_i && valid_q;
  assign hit      = valid_q && (cm_addr_o == rd_addr_i);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged_o[b*BW +: BW] = (hit && cm_be_o[b]) ? cm_data_o[b*BW +: BW]
                                                       : arr_rd_i[b*BW +: BW];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NB     = 4,
  parameter int BW     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NB-1:0]     be_i,
  input  logic [NB*BW-1:0]  dq_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  output logic [NB*BW-1:0]  dq_o,
  output logic              dq_oe_o
);
  localparam int W = NB * BW;

  cmd_e              kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NB-1:0]     be_q;
  logic              cap;
  logic              commit;
  logic [ADDR_W-1:0] cm_addr;
  logic [NB-1:0]     cm_be;
  logic [W-1:0]      cm_data;
  logic [W-1:0]      arr_rd;
  logic [W-1:0]      merged;
  logic              rd_vld_q;
  logic [W-1:0]      dout_q;

  lw_sram_cmd_reg #(.ADDR_W(ADDR_W), .NB(NB)) u_cmd (
    .clk_i, .rst_ni, .en_i, .we_i, .sleep_i, .addr_i, .be_i,
    .kind_o(kind_q), .addr_o(addr_q), .be_o(be_q)
  );

  assign cap = (kind_q == CMD_WR) && !sleep_i;

  lw_sram_wbuf #(.ADDR_W(ADDR_W), .NB(NB), .BW(BW)) u_wbuf (
    .clk_i, .rst_ni,
    .cap_i(cap), .addr_i(addr_q), .be_i(be_q), .data_i(dq_i),
    .rd_addr_i(addr_q), .arr_rd_i(arr_rd),
    .commit_o(commit), .cm_addr_o(cm_addr), .cm_be_o(cm_be),
    .cm_data_o(cm_data), .merged_o(merged)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .NB(NB), .BW(BW)) u_arr (
    .clk_i, .we_i(commit), .waddr_i(cm_addr), .wbe_i(cm_be),
    .wdata_i(cm_data), .raddr_i(addr_q), .rdata_o(arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      dout_q   <= '0;
    end else begin
      rd_vld_q <= !sleep_i && (kind_q == CMD_RD);
      if (!sleep_i && (kind_q == CMD_RD)) dout_q <= merged;
    end
  end

  assign dq_o = dout_q;
  // bus belongs to the controller during a late-write data cycle
  assign dq_oe_o = oe_i && rd_vld_q && (kind_q != CMD_WR) && !sleep_i;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic we_i,
  input logic oe_i,
  input logic sleep_i,
  input logic dq_oe_o
);
  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !dq_oe_o);

  // R9
  sleep_tri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);

  // R8
  wr_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i && !sleep_i) |=> !dq_oe_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || sleep_i) ##1 1'b1 |=> !dq_oe_o);

  // R2
  rd_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !we_i && !sleep_i) ##1 (!(en_i && we_i) && !sleep_i)
      |=> (sleep_i || (dq_oe_o == oe_i)));
endmodule

bind lw_sram lw_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .we_i(we_i),
  .oe_i(oe_i), .sleep_i(sleep_i), .dq_oe_o(dq_oe_o)
);

// File: tb/tb_lw_sram.sv
module tb_lw_sram;
  localparam int AW = 4, NB = 4, BW = 9, W = NB * BW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic en = 0, we = 0, oe = 1, slp = 0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] be = '0;
  logic [W-1:0]  dq_i = '0, dq_o;
  logic          dq_oe;

  lw_sram #(.ADDR_W(AW), .NB(NB), .BW(BW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .we_i(we), .addr_i(addr),
    .be_i(be), .dq_i(dq_i), .oe_i(oe), .sleep_i(slp),
    .dq_o(dq_o), .dq_oe_o(dq_oe)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] ref_m [DEPTH];
  logic p1_rd = 0, p1_wr = 0, p2_rd = 0;
  logic [W-1:0] p1_exp = '0, p2_exp = '0, p1_wd = '0;
  string p1_tag = "", p2_tag = "";

  function automatic logic [W-1:0] mk(int a, int k);
    return (W'(a) * 36'h0_0F0F_0F0F) ^ (W'(k) * 36'h0_5A5A_5A5B) ^ 36'h9_2345_6789;
  endfunction

  function automatic logic [W-1:0] bmask(logic [NB-1:0] b);
    logic [W-1:0] m = '0;
    for (int i = 0; i < NB; i++) if (b[i]) m[i*BW +: BW] = '1;
    return m;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(bit e, bit w, logic [AW-1:0] a, logic [NB-1:0] b,
                      logic [W-1:0] d, bit o, bit s, string tag);
    string t;
    @(negedge clk);
    if (p2_rd && !p1_wr && oe && !slp) begin
      chk(dq_oe === 1'b1, p2_tag, "drive", W'(dq_oe), W'(1));
      chk(dq_o === p2_exp, p2_tag, "data", dq_o, p2_exp);
    end else begin
      if (p2_rd && p1_wr)      t = "R8";
      else if (slp)            t = "R9";
      else if (p2_rd && !oe)   t = "R7";
      else                     t = "R10";
      chk(dq_oe === 1'b0, t, "no drive", W'(dq_oe), W'(0));
    end
    dq_i   = p1_wr ? p1_wd : ~mk(int'(a), 99);
    p2_rd  = p1_rd;
    p2_exp = p1_exp;
    p2_tag = p1_tag;
    p1_rd  = e && !w && !s;
    p1_wr  = e && w && !s;
    p1_tag = tag;
    if (p1_wr) begin
      ref_m[a] = (ref_m[a] & ~bmask(b)) | (d & bmask(b));
      p1_wd = d;
    end
    if (p1_rd) p1_exp = ref_m[a];
    en = e; we = w; addr = a; be = b; oe = o; slp = s;
  endtask

  task automatic nop(string tag);
    tick(0, 0, '0, '0, '0, 1, 0, tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R1", "reset no drive", W'(dq_oe), W'(0));

    // R3 R6: fill every word, each write commits the previous one
    for (int a = 0; a < DEPTH; a++) tick(1, 1, AW'(a), '1, mk(a, 1), 1, 0, "R3");
    // R2: back-to-back reads, last word still in the buffer
    for (int a = 0; a < DEPTH; a++) tick(1, 0, AW'(a), '0, '0, 1, 0, "R2");
    nop("R10"); nop("R10");

    // R4: write then read of the same word on the next cycle
    for (int a = 0; a < DEPTH; a++) begin
      tick(1, 1, AW'(a), '1, mk(a, 2), 1, 0, "R4");
      tick(1, 0, AW'(a), '0, '0, 1, 0, "R4");
      nop("R4");
    end

    // R5: every byte-enable pattern, merged on buffer hit
    for (int b = 0; b < (1 << NB); b++) begin
      tick(1, 1, AW'(3), NB'(b), mk(b, 3), 1, 0, "R5");
      tick(1, 0, AW'(3), '0, '0, 1, 0, "R5");
      tick(1, 0, AW'(2), '0, '0, 1, 0, "R5");
    end
    // R6: partial write committed by a second partial write to same word
    tick(1, 1, AW'(5), 4'b0011, mk(5, 4), 1, 0, "R6");
    tick(1, 1, AW'(5), 4'b1100, mk(5, 5), 1, 0, "R6");
    tick(1, 1, AW'(6), 4'b0101, mk(6, 6), 1, 0, "R6");
    tick(1, 0, AW'(5), '0, '0, 1, 0, "R6");
    tick(1, 0, AW'(6), '0, '0, 1, 0, "R6");
    nop("R6"); nop("R6");

    // R8: read immediately followed by write loses its slot
    tick(1, 0, AW'(7), '0, '0, 1, 0, "R8");
    tick(1, 1, AW'(8), '1, mk(8, 7), 1, 0, "R8");
    nop("R8");
    tick(1, 0, AW'(8), '0, '0, 1, 0, "R8");
    nop("R8"); nop("R8");

    // R7: oe low suppresses drive, then toggled asynchronously
    tick(1, 0, AW'(9), '0, '0, 0, 0, "R7");
    tick(0, 0, '0, '0, '0, 0, 0, "R7");
    tick(1, 0, AW'(9), '0, '0, 0, 0, "R7");
    nop("R7");
    nop("R7");
    #1 oe = 1'b0;
    #1 chk(dq_oe === 1'b0, "R7", "async off", W'(dq_oe), W'(0));
    oe = 1'b1;
    #1 chk(dq_oe === 1'b1, "R7", "async on", W'(dq_oe), W'(1));
    chk(dq_o === ref_m[9], "R7", "async data", dq_o, ref_m[9]);
    nop("R7"); nop("R7");

    // R9: commands under sleep are ignored, contents kept
    for (int k = 0; k < 4; k++) tick(1, (k % 2) == 0, AW'(0), '1, mk(0, 50 + k), 1, 1, "R9");
    tick(1, 0, AW'(0), '0, '0, 1, 1, "R9");
    nop("R9");
    tick(1, 0, AW'(0), '0, '0, 1, 0, "R9");
    tick(1, 0, AW'(15), '0, '0, 1, 0, "R9");
    nop("R9"); nop("R9");

    // R10: deselected cycles with write asserted change nothing
    for (int a = 0; a < DEPTH; a++) tick(0, 1, AW'(a), '1, mk(a, 70), 1, 0, "R10");
    for (int a = 0; a < DEPTH; a++) tick(1, 0, AW'(a), '0, '0, 1, 0, "R10");
    nop("R10"); nop("R10"); nop("R10");

    summary();
    $finish;
  end
endmodule